// File: doc/BRIEF.md
# Shuffle-Exchange Multistage Switch Network

This block steers up to eight requests from eight sources to eight sinks through three ranks of two-by-two switch elements. Before every rank the lanes are rewired by a perfect shuffle (the lane address rotated left by one bit). Each switch picks its setting from one bit of the request's destination tag, and the most significant bit is used first. Three ranks therefore deliver any request that nothing blocks to the sink whose index equals its tag. Each request carries a valid bit, a multicast flag, a 3-bit destination tag and an 8-bit data word.

The network is blocking. When two requests at one switch want the same output, the request on the upper input keeps it. The lower request is dropped, and its source is flagged in a blocked vector. A multicast request puts the last-rank switch into a broadcast state, so both sinks of that pair receive the word. Routing is combinational. The delivered lanes and the blocked vector are registered once, so results appear one clock after the inputs are presented.

Top module: `shx_network`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero at that edge: `out_valid`, `out_src`, `out_data` and `out_blocked`.
- R2: The outputs show the result for the inputs sampled at the previous rising edge. Until that edge, the outputs keep the earlier result.
- R3: A set of valid unicast requests that meets no conflict is delivered so that output `j` (field `j*3 +: 3` of `out_src`, `j*8 +: 8` of `out_data`) shows valid, the source index and the data word of the request whose tag equals `j`.
- R4: Rank k (k = 0, 1, 2) routes on tag bit 2-k: 0 selects the upper switch output and 1 the lower one. Switch s of a rank joins lanes 2s and 2s+1 after the shuffle. As a result, sources i and i+4 meet in the first rank and conflict when their tag MSBs are equal.
- R5: When both inputs of a switch want the same output, the upper input wins. The lower request is delivered nowhere, and bit `i` of `out_blocked` is set for its source `i`. A blocked request stays blocked in all later ranks.
- R6: A multicast request with tag D that meets no conflict is delivered to both outputs 2*(D>>1) and 2*(D>>1)+1, each showing the same source index and data.
- R7: In the last rank a multicast request claims both outputs. The upper input keeps everything it requests. A lower request that overlaps any output the upper one claims is dropped whole and flagged blocked, whether it is unicast or multicast.
- R8: An input with `in_valid` low has no effect, whatever its multicast flag, tag and data. An output that receives nothing shows zero valid, zero source and zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 8 | Request present, one bit per source |
| in_mcast | input | 8 | Multicast flag, one bit per source |
| in_dest | input | 24 | Destination tag, source i in bits i*3 +: 3 |
| in_data | input | 64 | Data word, source i in bits i*8 +: 8 |
| out_valid | output | 8 | Delivery present, one bit per sink |
| out_src | output | 24 | Originating source index, sink j in bits j*3 +: 3 |
| out_data | output | 64 | Delivered word, sink j in bits j*8 +: 8 |
| out_blocked | output | 8 | Request dropped on a conflict, one bit per source |

## Verification
Two full permutations that the network routes without conflict, identity and a rotate-by-one, show that the shuffle wiring and the per-rank tag bits deliver every source to the right sink. A single pair of sources four apart, and a full bit-reversal permutation, make the network block. The expected blocked masks (one dropped source, then the whole upper half) show which input has priority and in which rank the conflict is found. Two multicast pairs, with the multicast request first on the upper input and then on the lower one, separate all-or-nothing dropping from partial delivery. An all-invalid pattern with multicast flags set, a lone lower-input source, and a check taken before the clock edge cover ignored inputs, lower-input passage when the upper input is empty, and the one-cycle latency.

// File: rtl/shx_net_pkg.sv
package shx_net_pkg;

    parameter int unsigned NET_ADDR_W = 3;
    parameter int unsigned NET_DATA_W = 8;
    localparam int unsigned NET_PORTS = 1 << NET_ADDR_W;
    localparam int unsigned NET_SWITCHES = NET_PORTS / 2;

    typedef logic [NET_ADDR_W-1:0] addr_t;
    typedef logic [NET_DATA_W-1:0] word_t;

    typedef struct packed {
        logic  valid;
        logic  mcast;
        addr_t dest;
        addr_t src;
        word_t data;
    } lane_t;

    typedef enum logic [2:0] {
        SW_IDLE,
        SW_STRAIGHT,
        SW_CROSS,
        SW_BCAST_UP,
        SW_BCAST_LO
    } sw_state_e;

    // rotate left by one: lane wiring ahead of every rank
    function automatic addr_t shuffle_addr(input addr_t a);
        return {a[NET_ADDR_W-2:0], a[NET_ADDR_W-1]};
    endfunction

    // complement one address bit: partner lane inside a switch
    function automatic addr_t exchange_addr(input addr_t a, input int unsigned b);
        addr_t r;
        r = a;
        r[b] = ~a[b];
        return r;
    endfunction

    // swap the outermost bits, middle bits kept
    function automatic addr_t butterfly_addr(input addr_t a);
        addr_t r;
        r = a;
        r[NET_ADDR_W-1] = a[0];
        r[0] = a[NET_ADDR_W-1];
        return r;
    endfunction

endpackage

// File: rtl/shx_switch.sv
module shx_switch
    import shx_net_pkg::*;
#(
    parameter int unsigned ROUTE_BIT = 0,
    parameter bit          BCAST_EN  = 1'b0
) (
    input  lane_t up_i,
    input  lane_t lo_i,
    output lane_t up_o,
    output lane_t lo_o,
    output logic  lo_drop_o
);

    // request bits: [0] upper output, [1] lower output
    logic [1:0] up_req;
    logic [1:0] lo_req;
    logic       lo_grant;
    lane_t      lo_kept;
    sw_state_e  state;

    function automatic logic [1:0] port_request(input lane_t l);
        if (!l.valid) return 2'b00;
        if (BCAST_EN && l.mcast) return 2'b11;
        return l.dest[ROUTE_BIT] ? 2'b10 : 2'b01;
    endfunction

    always_comb begin
        up_req    = port_request(up_i);
        lo_req    = port_request(lo_i);
        lo_grant  = lo_i.valid && ((up_req & lo_req) == 2'b00);
        lo_kept   = lo_grant ? lo_i : '0;
        lo_drop_o = lo_i.valid && !lo_grant;

        if (up_req == 2'b11)
            state = SW_BCAST_UP;
        else if (lo_grant && lo_req == 2'b11)
            state = SW_BCAST_LO;
        else if (up_req == 2'b01 || (lo_grant && lo_req == 2'b10))
            state = SW_STRAIGHT;
        else if (up_req == 2'b10 || (lo_grant && lo_req == 2'b01))
            state = SW_CROSS;
        else
            state = SW_IDLE;

        case (state)
            SW_STRAIGHT: begin up_o = up_i;    lo_o = lo_kept; end
            SW_CROSS:    begin up_o = lo_kept; lo_o = up_i;    end
            SW_BCAST_UP: begin up_o = up_i;    lo_o = up_i;    end
            SW_BCAST_LO: begin up_o = lo_kept; lo_o = lo_kept; end
            default:     begin up_o = '0;      lo_o = '0;      end
        endcase
    end

    always_comb begin
        // R5
        if (up_i.valid) upper_kept_chk: assert (up_o == up_i || lo_o == up_i);
        // R8
        if (!up_i.valid && !lo_i.valid) idle_switch_chk: assert (up_o == '0 && lo_o == '0);
    end

endmodule

// File: rtl/shx_stage.sv
module shx_stage
    import shx_net_pkg::*;
#(
    parameter int unsigned STAGE = 0
) (
    input  lane_t [NET_PORTS-1:0] lanes_i,
    output lane_t [NET_PORTS-1:0] lanes_o,
    output logic  [NET_PORTS-1:0] drop_o
);

    localparam int unsigned ROUTE_BIT = NET_ADDR_W - 1 - STAGE;
    localparam bit          LAST_RANK = (STAGE == NET_ADDR_W - 1);

    lane_t [NET_PORTS-1:0]    shuffled;
    logic  [NET_SWITCHES-1:0] sw_drop;
    addr_t                    sw_src [NET_SWITCHES];

    for (genvar j = 0; j < NET_PORTS; j++) begin : g_wire
        localparam addr_t DST = shuffle_addr(addr_t'(j));
        assign shuffled[DST] = lanes_i[j];
    end

    for (genvar s = 0; s < NET_SWITCHES; s++) begin : g_sw
        localparam addr_t UP_LANE = addr_t'(2 * s);
        localparam addr_t LO_LANE = exchange_addr(UP_LANE, 0);
        shx_switch #(
            .ROUTE_BIT(ROUTE_BIT),
            .BCAST_EN (LAST_RANK)
        ) u_sw (
            .up_i     (shuffled[UP_LANE]),
            .lo_i     (shuffled[LO_LANE]),
            .up_o     (lanes_o[UP_LANE]),
            .lo_o     (lanes_o[LO_LANE]),
            .lo_drop_o(sw_drop[s])
        );
        assign sw_src[s] = shuffled[LO_LANE].src;
    end

    always_comb begin
        drop_o = '0;
        for (int s = 0; s < NET_SWITCHES; s++) begin
            if (sw_drop[s]) drop_o[sw_src[s]] = 1'b1;
        end
    end

endmodule

// File: rtl/shx_network.sv
module shx_network
    import shx_net_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NET_PORTS-1:0]             in_valid,
    input  logic [NET_PORTS-1:0]             in_mcast,
    input  logic [NET_PORTS*NET_ADDR_W-1:0]  in_dest,
    input  logic [NET_PORTS*NET_DATA_W-1:0]  in_data,
    output logic [NET_PORTS-1:0]             out_valid,
    output logic [NET_PORTS*NET_ADDR_W-1:0]  out_src,
    output logic [NET_PORTS*NET_DATA_W-1:0]  out_data,
    output logic [NET_PORTS-1:0]             out_blocked
);

    lane_t [NET_PORTS-1:0] chain [NET_ADDR_W+1];
    logic  [NET_PORTS-1:0] drops [NET_ADDR_W];
    logic  [NET_PORTS-1:0] blocked_comb;
    lane_t [NET_PORTS-1:0] out_q;
    logic  [NET_PORTS-1:0] blocked_q;

    always_comb begin
        for (int i = 0; i < NET_PORTS; i++) begin
            chain[0][i] = '0;
            if (in_valid[i]) begin
                chain[0][i].valid = 1'b1;
                chain[0][i].mcast = in_mcast[i];
                chain[0][i].dest  = in_dest[i*NET_ADDR_W +: NET_ADDR_W];
                chain[0][i].src   = addr_t'(i);
                chain[0][i].data  = in_data[i*NET_DATA_W +: NET_DATA_W];
            end
        end
    end

    for (genvar k = 0; k < NET_ADDR_W; k++) begin : g_rank
        shx_stage #(.STAGE(k)) u_stage (
            .lanes_i(chain[k]),
            .lanes_o(chain[k+1]),
            .drop_o (drops[k])
        );
    end

    always_comb begin
        blocked_comb = '0;
        for (int k = 0; k < NET_ADDR_W; k++) blocked_comb |= drops[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q     <= '0;
            blocked_q <= '0;
        end else begin
            out_q     <= chain[NET_ADDR_W];
            blocked_q <= blocked_comb;
        end
    end

    for (genvar j = 0; j < NET_PORTS; j++) begin : g_out
        assign out_valid[j]                           = out_q[j].valid;
        assign out_src[j*NET_ADDR_W +: NET_ADDR_W]    = out_q[j].src;
        assign out_data[j*NET_DATA_W +: NET_DATA_W]   = out_q[j].data;
        assign out_blocked[j]                         = blocked_q[j];

        // R5
        blocked_had_req_chk: assert property (@(posedge clk) disable iff (rst)
            out_blocked[j] |-> $past(in_valid[j]));

        // R3
        delivered_src_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid[j] |-> ((($past(in_valid) & ~out_blocked) >> out_src[j*NET_ADDR_W +: NET_ADDR_W]) & 1) != 0);

        // R8
        idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
            !out_valid[j] |-> (out_src[j*NET_ADDR_W +: NET_ADDR_W] == '0
                              && out_data[j*NET_DATA_W +: NET_DATA_W] == '0));
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (|out_valid) |-> $past(|in_valid));

endmodule

// File: tb/shx_network_bench.sv
module shx_network_bench;
    import shx_net_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  in_valid = '0;
    logic [7:0]  in_mcast = '0;
    logic [23:0] in_dest = '0;
    logic [63:0] in_data = '0;
    logic [7:0]  out_valid;
    logic [23:0] out_src;
    logic [63:0] out_data;
    logic [7:0]  out_blocked;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    shx_network u_shx_network (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_mcast(in_mcast), .in_dest(in_dest), .in_data(in_data),
        .out_valid(out_valid), .out_src(out_src), .out_data(out_data), .out_blocked(out_blocked)
    );

    // {valid[47:40], mcast[39:32], dest[31:8] (source 7 .. source 0), blocked[7:0]}
    localparam int NV = 9;
    localparam logic [47:0] VEC [NV] = '{
        {8'hFF, 8'h00, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'h00}, // R3 identity
        {8'hFF, 8'h00, {3'd0,3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1}, 8'h00}, // R3 rotate by one
        {8'h11, 8'h00, {3'd0,3'd0,3'd0,3'd1,3'd0,3'd0,3'd0,3'd0}, 8'h10}, // R4 sources 0 and 4
        {8'hFF, 8'h00, {3'd7,3'd3,3'd5,3'd1,3'd6,3'd2,3'd4,3'd0}, 8'hF0}, // R5 bit reversal
        {8'h08, 8'h08, {3'd0,3'd0,3'd0,3'd0,3'd4,3'd0,3'd0,3'd0}, 8'h00}, // R6 multicast
        {8'h03, 8'h01, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd5,3'd4}, 8'h02}, // R7 upper multicast
        {8'h03, 8'h02, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd4,3'd5}, 8'h02}, // R7 lower multicast
        {8'h00, 8'hFF, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'h00}, // R8 all invalid
        {8'h10, 8'h00, {3'd0,3'd0,3'd0,3'd1,3'd0,3'd0,3'd0,3'd0}, 8'h00}  // R4 lone lower input
    };

    function automatic string vec_req(input int v);
        case (v)
            0, 1:    return "R3";
            2, 8:    return "R4";
            3:       return "R5";
            4:       return "R6";
            5, 6:    return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic apply_vec(input int v);
        logic [47:0] e;
        e = VEC[v];
        in_valid = e[47:40];
        in_mcast = e[39:32];
        in_dest  = e[31:8];
        for (int i = 0; i < 8; i++) in_data[i*8 +: 8] = {4'(v), 4'(i)};
    endtask

    task automatic check_vec(input int v);
        logic [47:0] e;
        logic [2:0]  d;
        logic        ev;
        logic [2:0]  es;
        logic [7:0]  ed;
        e = VEC[v];
        check(out_blocked == e[7:0], (v == 2) ? "R5" : vec_req(v), 64'(out_blocked), 64'(e[7:0]));
        for (int j = 0; j < 8; j++) begin
            ev = 1'b0; es = '0; ed = '0;
            for (int i = 0; i < 8; i++) begin
                d = e[8 + i*3 +: 3];
                if (e[40+i] && !e[i] &&
                    (e[32+i] ? (d[2:1] == 2'(j >> 1)) : (d == 3'(j)))) begin
                    ev = 1'b1; es = 3'(i); ed = {4'(v), 4'(i)};
                end
            end
            check({out_valid[j], out_src[j*3 +: 3], out_data[j*8 +: 8]} == {ev, es, ed},
                  vec_req(v),
                  64'({out_valid[j], out_src[j*3 +: 3], out_data[j*8 +: 8]}),
                  64'({ev, es, ed}));
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog actual=%0d expected<=20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset clears everything even with requests driven
        in_valid = 8'hFF;
        in_dest  = {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0};
        in_data  = 64'hA5A5_A5A5_A5A5_A5A5;
        repeat (3) @(negedge clk);
        check(out_valid == '0, "R1", 64'(out_valid), 64'h0);
        check(out_src == '0 && out_data == '0, "R1", out_data, 64'h0);
        check(out_blocked == '0, "R1", 64'(out_blocked), 64'h0);
        rst = 1'b0;

        // table walk: drive at a falling edge, result after the next rising edge
        for (int v = 0; v < NV; v++) begin
            apply_vec(v);
            @(negedge clk);
            check_vec(v);
        end

        // R2: new inputs are not visible before the next rising edge
        apply_vec(0);
        @(negedge clk);
        apply_vec(3);
        #1;
        check(out_blocked == 8'h00 && out_valid == 8'hFF, "R2",
              64'({out_blocked, out_valid}), 64'h00FF);
        @(negedge clk);
        check(out_blocked == 8'hF0, "R2", 64'(out_blocked), 64'hF0);

        // R1: reset in mid-run clears the outputs
        rst = 1'b1;
        @(negedge clk);
        check(out_valid == '0 && out_blocked == '0, "R1",
              64'({out_blocked, out_valid}), 64'h0);
        rst = 1'b0;

        finish_run();
    end

endmodule